// File: doc/BRIEF.md
# Voice Interrupt Priority Arbiter

The arbiter collects the interrupt requests raised by up to 31 synthesis voices and hands them to the host one at a time. Each voice can raise two kinds of request. A sample-end request means the wavetable position has reached its boundary. A ramp-done request means the volume envelope has finished. The arbiter keeps one pending vector for each kind and sets a bit whenever the matching one-cycle set pulse arrives.

The host asks for service with a single-cycle acknowledge strobe, issued when it selects the "fetch voice interrupt" function. On each acknowledge the arbiter serves one voice. Sample-end requests always beat ramp-done requests, and inside one class the lowest voice number wins. The arbiter clears that pending bit and sends a one-cycle clear pulse to the served voice's control register, so the voice can drop its own flag bit 7. It also latches a status byte that the host reads back at leisure. The block drives the two class summary bits of the global interrupt status byte and merges them with the status bits from other sources. The interrupt line is high exactly when that byte is non-zero. A synchronous global clear empties both vectors.

Top module: `voice_irq_arbiter`

## Requirements
- R1: A set pulse on `wave_set[v]` or `ramp_set[v]` makes voice v pending in that class from the next clock edge, and the class summary bit (`irq_status[5]` for sample-end, `irq_status[6]` for ramp-done) is high while any voice of that class is pending.
- R2: On an acknowledge, a pending sample-end request is always served before any ramp-done request, whatever the voice numbers involved.
- R3: Within the served class the lowest pending voice number is chosen. Exactly one bit of `wave_clr` or `ramp_clr` (the one for the served voice and class) is high for the single cycle after the acknowledge edge. Both vectors are zero at all other times.
- R4: The latched status byte is 0x60 plus the voice number for a sample-end service (bits 7:5 = 011), 0x80 plus the voice number for a ramp-done service (bits 7:5 = 100), and 0xE8 when an acknowledge finds nothing pending.
- R5: Serving a voice removes only that voice's pending bit. A class summary bit falls in the cycle after the acknowledge that empties its vector.
- R6: `irq_status` takes bits 7, 4..0 from `ext_status`, ignores bits 5 and 6 of `ext_status`, and replaces them with the two summary bits. `irq_line` is high exactly when `irq_status` is non-zero.
- R7: `glb_clear` empties both vectors at the next edge. It overrides set pulses and an acknowledge in the same cycle, produces no clear pulse and leaves the status byte unchanged.
- R8: The status byte changes only on an acknowledge. Between acknowledges it holds its value however many cycles pass.
- R9: A set pulse for the same voice and class as the voice served in that same cycle leaves the bit pending.
- R10: After reset both vectors are empty, the status byte reads 0xE8 and no clear pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_clear | input | 1 | Synchronous clear of both pending vectors |
| wave_set | input | NUM_VOICES | One-cycle sample-end request per voice |
| ramp_set | input | NUM_VOICES | One-cycle ramp-done request per voice |
| ack | input | 1 | Host acknowledge strobe: serve one voice |
| ext_status | input | 8 | Status bits from other interrupt sources (bits 5,6 ignored) |
| status_code | output | 8 | Latched service status byte |
| wave_clr | output | NUM_VOICES | One-cycle clear pulse to the served voice's wave control register |
| ramp_clr | output | NUM_VOICES | One-cycle clear pulse to the served voice's ramp control register |
| irq_status | output | 8 | Merged global interrupt status byte |
| irq_line | output | 1 | Interrupt request, high while any status bit is set |

## Verification
A wrong pending bit shows at the ports on the next acknowledge. The status byte then names the wrong voice or class, or reads 0xE8 too early, and the clear pulse appears on the wrong line one cycle after the acknowledge edge. A summary bit that is stuck shows at once, in the cycle after the vector should have emptied, as a wrong `irq_status` bit and an `irq_line` that will not fall. Sweeping every voice in both classes, draining full vectors in order and running long pseudo-random mixes of sets, acknowledges and clears against a bench-side model exposes each of these within a few cycles of its cause.

// File: rtl/vip_pkg.sv
package vip_pkg;

   localparam int unsigned VOICE_FIELD_W = 5;
   localparam int unsigned MAX_VOICES    = 31;

   localparam logic [7:0] CODE_IDLE = 8'hE8;
   localparam logic [2:0] TAG_WAVE  = 3'b011;
   localparam logic [2:0] TAG_RAMP  = 3'b100;

   typedef enum logic [1:0] {
      SRV_NONE = 2'd0,
      SRV_WAVE = 2'd1,
      SRV_RAMP = 2'd2
   } srv_kind_e;

   function automatic logic [7:0] make_code(input srv_kind_e kind,
                                            input logic [VOICE_FIELD_W-1:0] voice);
      logic [7:0] code;
      case (kind)
         SRV_WAVE: code = {TAG_WAVE, voice};
         SRV_RAMP: code = {TAG_RAMP, voice};
         default:  code = CODE_IDLE;
      endcase
      return code;
   endfunction

endpackage

// File: rtl/vip_pend_vec.sv
module vip_pend_vec #(
   parameter int unsigned WIDTH = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] pend_o
);

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_o[b] <= 1'b0;
            end else if (flush) begin
               pend_o[b] <= 1'b0;
            end else if (set_i[b]) begin
               pend_o[b] <= 1'b1;
            end else if (clr_i[b]) begin
               pend_o[b] <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vip_low_pick.sv
module vip_low_pick #(
   parameter int unsigned WIDTH      = 31,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned PICK_STYLE = 1
) (
   input  logic [WIDTH-1:0] req_i,
   output logic             found_o,
   output logic [WIDTH-1:0] onehot_o,
   output logic [IDX_W-1:0] idx_o
);

   assign found_o = |req_i;

   generate
      if (PICK_STYLE == 0) begin : g_scan
         always_comb begin
            onehot_o = '0;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               if (req_i[i]) begin
                  onehot_o    = '0;
                  onehot_o[i] = 1'b1;
               end
            end
         end
      end else begin : g_chain
         logic [WIDTH:0] seen;
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            assign seen[i+1]   = seen[i] | req_i[i];
            assign onehot_o[i] = req_i[i] & ~seen[i];
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (onehot_o[i]) begin
            idx_o = idx_o | IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/voice_irq_arbiter.sv
module voice_irq_arbiter
   import vip_pkg::*;
#(
   parameter int unsigned NUM_VOICES = 31,
   parameter int unsigned PICK_STYLE = 1,
   parameter int unsigned WAVE_BIT   = 5,
   parameter int unsigned RAMP_BIT   = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  glb_clear,
   input  logic [NUM_VOICES-1:0] wave_set,
   input  logic [NUM_VOICES-1:0] ramp_set,
   input  logic                  ack,
   input  logic [7:0]            ext_status,
   output logic [7:0]            status_code,
   output logic [NUM_VOICES-1:0] wave_clr,
   output logic [NUM_VOICES-1:0] ramp_clr,
   output logic [7:0]            irq_status,
   output logic                  irq_line
);

   localparam int unsigned VW = VOICE_FIELD_W;
   localparam logic [7:0] SUM_MASK = (8'h1 << WAVE_BIT) | (8'h1 << RAMP_BIT);

   generate
      if (NUM_VOICES < 1 || NUM_VOICES > MAX_VOICES) begin : g_bad_voices
         $error("voice_irq_arbiter: NUM_VOICES must lie in 1..31");
      end
      if (PICK_STYLE > 1) begin : g_bad_style
         $error("voice_irq_arbiter: PICK_STYLE must be 0 or 1");
      end
      if (WAVE_BIT > 7 || RAMP_BIT > 7 || WAVE_BIT == RAMP_BIT) begin : g_bad_bits
         $error("voice_irq_arbiter: summary bit positions invalid");
      end
   endgenerate

   logic [NUM_VOICES-1:0] wave_pend, ramp_pend;
   logic [NUM_VOICES-1:0] wave_oh, ramp_oh;
   logic [NUM_VOICES-1:0] wave_take, ramp_take;
   logic [VW-1:0]         wave_idx, ramp_idx;
   logic                  wave_any, ramp_any;
   logic                  serve_ok;
   srv_kind_e             kind;
   logic [7:0]            next_code;

   vip_pend_vec #(.WIDTH(NUM_VOICES)) wave_vec_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (glb_clear),
      .set_i  (wave_set),
      .clr_i  (wave_take),
      .pend_o (wave_pend)
   );

   vip_pend_vec #(.WIDTH(NUM_VOICES)) ramp_vec_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (glb_clear),
      .set_i  (ramp_set),
      .clr_i  (ramp_take),
      .pend_o (ramp_pend)
   );

   vip_low_pick #(.WIDTH(NUM_VOICES), .IDX_W(VW), .PICK_STYLE(PICK_STYLE)) wave_pick_i (
      .req_i    (wave_pend),
      .found_o  (wave_any),
      .onehot_o (wave_oh),
      .idx_o    (wave_idx)
   );

   vip_low_pick #(.WIDTH(NUM_VOICES), .IDX_W(VW), .PICK_STYLE(PICK_STYLE)) ramp_pick_i (
      .req_i    (ramp_pend),
      .found_o  (ramp_any),
      .onehot_o (ramp_oh),
      .idx_o    (ramp_idx)
   );

   always_comb begin
      serve_ok  = ack & ~glb_clear;
      wave_take = '0;
      ramp_take = '0;
      kind      = SRV_NONE;
      next_code = make_code(SRV_NONE, '0);
      if (wave_any) begin
         kind      = SRV_WAVE;
         next_code = make_code(SRV_WAVE, wave_idx);
         if (serve_ok) wave_take = wave_oh;
      end else if (ramp_any) begin
         kind      = SRV_RAMP;
         next_code = make_code(SRV_RAMP, ramp_idx);
         if (serve_ok) ramp_take = ramp_oh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_code <= CODE_IDLE;
         wave_clr    <= '0;
         ramp_clr    <= '0;
      end else begin
         wave_clr <= wave_take;
         ramp_clr <= ramp_take;
         if (serve_ok) begin
            status_code <= (kind == SRV_NONE) ? CODE_IDLE : next_code;
         end
      end
   end

   always_comb begin
      irq_status           = ext_status & ~SUM_MASK;
      irq_status[WAVE_BIT] = wave_any;
      irq_status[RAMP_BIT] = ramp_any;
   end

   assign irq_line = |irq_status;

endmodule

// File: rtl/voice_irq_arbiter_chk.sv
module voice_irq_arbiter_chk #(
   parameter int unsigned NUM_VOICES = 31
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  glb_clear,
   input logic                  ack,
   input logic [7:0]            ext_status,
   input logic [7:0]            status_code,
   input logic [NUM_VOICES-1:0] wave_clr,
   input logic [NUM_VOICES-1:0] ramp_clr,
   input logic [7:0]            irq_status,
   input logic                  irq_line
);

   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wave_clr, ramp_clr})) else $error("clear pulses not one-hot"); // R3

   AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> (wave_clr == '0) && (ramp_clr == '0)) else $error("clear without acknowledge"); // R3

   AST_WAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !glb_clear && irq_status[5]) |=> (wave_clr != '0) && (status_code[7:5] == 3'b011))
      else $error("sample-end request not served first"); // R2

   AST_RAMP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !glb_clear && !irq_status[5] && irq_status[6]) |=> (ramp_clr != '0) && (status_code[7:5] == 3'b100))
      else $error("ramp service code wrong"); // R4

   AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !glb_clear && !irq_status[5] && !irq_status[6]) |=> (status_code == 8'hE8) && (wave_clr == '0) && (ramp_clr == '0))
      else $error("idle code wrong"); // R4

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack || glb_clear) |=> $stable(status_code)) else $error("status changed without service"); // R8

   AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      glb_clear |=> !irq_status[5] && !irq_status[6] && (wave_clr == '0) && (ramp_clr == '0))
      else $error("clear did not empty vectors"); // R7

   AST_EXT_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      ((ext_status & 8'h9F) != 8'h00) |-> irq_line) else $error("external source did not raise line"); // R6

endmodule

bind voice_irq_arbiter voice_irq_arbiter_chk #(.NUM_VOICES(NUM_VOICES)) chk_i (.*);

// File: tb/voice_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module voice_irq_arbiter_tb_top;

   localparam int N = 31;
   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         glb_clear = 1'b0;
   logic [N-1:0] wave_set = '0;
   logic [N-1:0] ramp_set = '0;
   logic         ack = 1'b0;
   logic [7:0]   ext_status = 8'h00;
   logic [7:0]   status_code;
   logic [N-1:0] wave_clr, ramp_clr;
   logic [7:0]   irq_status;
   logic         irq_line;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [N-1:0] mw = '0, mr = '0;
   logic [7:0]   mstat = 8'hE8;

   always #4 clk = ~clk;

   voice_irq_arbiter #(.NUM_VOICES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .glb_clear(glb_clear),
      .wave_set(wave_set), .ramp_set(ramp_set), .ack(ack),
      .ext_status(ext_status), .status_code(status_code),
      .wave_clr(wave_clr), .ramp_clr(ramp_clr),
      .irq_status(irq_status), .irq_line(irq_line)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic step(input logic [N-1:0] ws, input logic [N-1:0] rs,
                       input logic a, input logic gc, input logic [7:0] ex, input string ctx);
      logic [N-1:0] ewc, erc;
      logic [7:0]   eirq;
      int v;
      ewc = '0; erc = '0;
      if (gc) begin
         mw = '0; mr = '0;
      end else begin
         if (a) begin
            if (mw != '0) begin
               v = lowest(mw); ewc = ONE << v; mstat = 8'h60 + 8'(v);
            end else if (mr != '0) begin
               v = lowest(mr); erc = ONE << v; mstat = 8'h80 + 8'(v);
            end else begin
               mstat = 8'hE8;
            end
         end
         mw = (mw & ~ewc) | ws;
         mr = (mr & ~erc) | rs;
      end
      eirq = (ex & 8'h9F) | ((mw != '0) ? 8'h20 : 8'h00) | ((mr != '0) ? 8'h40 : 8'h00);
      wave_set = ws; ramp_set = rs; ack = a; glb_clear = gc; ext_status = ex;
      @(posedge clk);
      @(negedge clk);
      chk(status_code == mstat, {ctx, " R4 R8 status"}, 64'(status_code), 64'(mstat));
      chk(wave_clr == ewc, {ctx, " R3 wave_clr"}, 64'(wave_clr), 64'(ewc));
      chk(ramp_clr == erc, {ctx, " R3 ramp_clr"}, 64'(ramp_clr), 64'(erc));
      chk(irq_status == eirq, {ctx, " R5 R6 irq_status"}, 64'(irq_status), 64'(eirq));
      chk(irq_line == (eirq != 8'h00), {ctx, " R6 irq_line"}, 64'(irq_line), 64'(eirq != 8'h00));
      wave_set = '0; ramp_set = '0; ack = 1'b0; glb_clear = 1'b0;
   endtask

   initial begin : watchdog
      #(8 * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(status_code == 8'hE8, "R10 status", 64'(status_code), 64'hE8);
      chk(wave_clr == '0 && ramp_clr == '0, "R10 clears", 64'(wave_clr | ramp_clr), 64'h0);
      chk(irq_status == 8'h00, "R10 irq_status", 64'(irq_status), 64'h0);
      chk(irq_line == 1'b0, "R10 irq_line", 64'(irq_line), 64'h0);

      // R1 R2 R4 R5: every voice in both classes
      for (int v = 0; v < N; v++) begin
         step(ONE << v, ONE << v, 1'b0, 1'b0, 8'h00, "R1 set");
         step('0, '0, 1'b1, 1'b0, 8'h00, "R2 wave first");
         step('0, '0, 1'b1, 1'b0, 8'h00, "R4 ramp next");
         step('0, '0, 1'b1, 1'b0, 8'h00, "R4 idle");
      end

      // R3: full vectors drained lowest first, sample-end class ahead
      step({N{1'b1}}, {N{1'b1}}, 1'b0, 1'b0, 8'h00, "R1 fill");
      for (int k = 0; k < 2 * N + 1; k++) step('0, '0, 1'b1, 1'b0, 8'h00, "R3 drain");

      // R2: high sample-end voice beats low ramp voice
      step(ONE << (N - 1), ONE, 1'b0, 1'b0, 8'h00, "R2 setup");
      step('0, '0, 1'b1, 1'b0, 8'h00, "R2 cross");
      step('0, '0, 1'b1, 1'b0, 8'h00, "R2 cross ramp");

      // R9: set and serve the same voice in one cycle
      step(ONE << 3, '0, 1'b0, 1'b0, 8'h00, "R9 setup");
      step(ONE << 3, '0, 1'b1, 1'b0, 8'h00, "R9 collide");
      step('0, '0, 1'b1, 1'b0, 8'h00, "R9 again");
      step('0, ONE << 7, 1'b0, 1'b0, 8'h00, "R9 ramp setup");
      step('0, ONE << 7, 1'b1, 1'b0, 8'h00, "R9 ramp collide");

      // R8: status holds over idle cycles
      for (int k = 0; k < 5; k++) step('0, '0, 1'b0, 1'b0, 8'h00, "R8 hold");

      // R7: clear overrides set and acknowledge
      step(ONE << 2, ONE << 9, 1'b0, 1'b0, 8'h00, "R7 setup");
      step(ONE << 4, ONE << 1, 1'b1, 1'b1, 8'h00, "R7 clear");
      step('0, '0, 1'b1, 1'b0, 8'h00, "R7 after");

      // R6: external status merge, bits 5 and 6 of ext ignored
      step('0, '0, 1'b0, 1'b0, 8'h60, "R6 ext ignored");
      step('0, '0, 1'b0, 1'b0, 8'h01, "R6 ext low");
      step('0, '0, 1'b0, 1'b0, 8'h80, "R6 ext high");
      step(ONE << 5, '0, 1'b0, 1'b0, 8'h04, "R6 merge");
      step('0, '0, 1'b1, 1'b0, 8'h00, "R6 drop");

      // pseudo-random mix
      lf = 32'h1D2C3B4A;
      for (int k = 0; k < 3000; k++) begin
         logic [N-1:0] ws, rs;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         ws = (lf[0] & lf[1]) ? (ONE << (int'(lf[9:4]) % N)) : '0;
         rs = (lf[2] & lf[3]) ? (ONE << (int'(lf[17:12]) % N)) : '0;
         step(ws, rs, lf[20], lf[27:22] == 6'd0, {lf[31], 2'b00, lf[30:29], 3'b000},
              "R1 R2 R3 R5 R7 R9 mix");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule